// File: doc/BRIEF.md
# Edge-List to Neighbour-Table Builder

This block turns a graph given as a plain list of directed edges into the per-node tables that a message-passing engine reads. Each edge is a (source, destination) pair of node indices. For every new graph, the block builds four tables. Two hold each node's count of incoming and outgoing edges. The third holds, for each node, the start of that node's block in the fourth table. The fourth table lists the sources of each node's incoming edges, with each node's sources stored together.

A run begins with a start pulse, which also supplies the node count and the edge count for this graph. The block first zeroes the degree entries of the nodes in use. It then takes exactly the given number of edges over a valid/ready stream, storing each edge and counting degrees as it arrives. Next, a pass over the nodes forms the block starts. A final pass over the stored edges places each source into its destination's block. A one-cycle done pulse marks that the tables can be read through combinational read ports.

Top module: `coo_nbr_builder`

## Requirements
- R1: After reset, busy, done, err and in_ready are 0 and every degree, offset and neighbour entry reads 0.
- R2: A start pulse while idle captures num_nodes and num_edges and raises busy in the next cycle. A start pulse while busy is ignored and does not change the graph being built.
- R3: in_ready is high only during the edge intake phase. Exactly num_edges edges are accepted, one on each cycle where in_valid and in_ready are both high. A source that sees in_ready low must hold its edge until it is accepted.
- R4: After done, for every node n below num_nodes, the in-degree read at n equals the number of valid accepted edges whose destination is n. The out-degree read at n equals the number of valid accepted edges whose source is n. Values left over from an earlier graph are cleared.
- R5: After done, the offset read at node 0 is 0. The offset read at node n equals the sum of the in-degrees of nodes 0 to n-1.
- R6: After done, the neighbour slots from offset(d) to offset(d)+indeg(d)-1 hold the sources of the valid edges into node d. They appear in the order those edges were accepted.
- R7: An edge whose source or destination is at or above num_nodes sets err. It changes no degree, offset or neighbour entry. err stays set until the next accepted start, which clears it.
- R8: done is a single-cycle pulse, asserted in the same cycle that busy falls.
- R9: With num_edges equal to 0, the block takes no edges. All degrees and offsets of the nodes in use read 0 after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse for a new graph |
| num_nodes | input | $clog2(MAX_NODES+1) | Node count of the graph, captured at start |
| num_edges | input | $clog2(MAX_EDGES+1) | Edge count of the graph, captured at start |
| in_valid | input | 1 | Edge stream valid |
| in_ready | output | 1 | Edge stream ready |
| in_src | input | $clog2(MAX_NODES) | Source node of the offered edge |
| in_dst | input | $clog2(MAX_NODES) | Destination node of the offered edge |
| busy | output | 1 | High from start until tables are complete |
| done | output | 1 | One-cycle pulse when the tables are complete |
| err | output | 1 | An out-of-range edge was seen in this graph |
| rd_node | input | $clog2(MAX_NODES) | Node index for the degree and offset reads |
| rd_indeg | output | $clog2(MAX_EDGES+1) | In-degree of rd_node |
| rd_outdeg | output | $clog2(MAX_EDGES+1) | Out-degree of rd_node |
| rd_offset | output | $clog2(MAX_EDGES+1) | Start of rd_node's block in the neighbour table |
| rd_slot | input | $clog2(MAX_EDGES) | Neighbour table slot to read |
| rd_nbr | output | $clog2(MAX_NODES) | Source node stored at rd_slot |

## Verification
The hardest situation to reach is a node whose neighbour block must grow while earlier edges for other destinations are still pending. The same case is needed while the edge stream stalls and an out-of-range edge sits between valid ones. The bench drives a graph with several repeated destinations. It inserts idle gaps on in_valid and places bad edges in the middle of the list, so the per-node cursors and the skip logic are exercised in one run. A smaller graph with no edges, following a dense one, shows that the tables are cleared between graphs. A start pulse issued mid-build shows that a running build is not disturbed.

// File: rtl/coo_nbr_pkg.sv
package coo_nbr_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CLEAR,
    PH_TAKE,
    PH_SCAN,
    PH_PLACE
  } phase_e;
endpackage

// File: rtl/coo_deg_table.sv
module coo_deg_table #(
  parameter int N  = 16,
  parameter int CW = 6,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [IW-1:0] clr_idx,
  input  logic          inc,
  input  logic [IW-1:0] inc_idx,
  input  logic [IW-1:0] rd_a_idx,
  output logic [CW-1:0] rd_a,
  input  logic [IW-1:0] rd_b_idx,
  output logic [CW-1:0] rd_b
);
  logic [CW-1:0] cnt [N];

  for (genvar g = 0; g < N; g++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cnt[g] <= '0;
      else if (clr && clr_idx == IW'(g))
        cnt[g] <= '0;
      else if (inc && inc_idx == IW'(g))
        cnt[g] <= cnt[g] + CW'(1);
    end
  end

  assign rd_a = cnt[rd_a_idx];
  assign rd_b = cnt[rd_b_idx];
endmodule

// File: rtl/coo_block_cursor.sv
module coo_block_cursor #(
  parameter int N  = 16,
  parameter int CW = 6,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init,
  input  logic [IW-1:0] init_idx,
  input  logic [CW-1:0] init_val,
  input  logic          bump,
  input  logic [IW-1:0] bump_idx,
  output logic [CW-1:0] cur_val,
  input  logic [IW-1:0] rd_idx,
  output logic [CW-1:0] rd_off
);
  logic [CW-1:0] base [N];
  logic [CW-1:0] cur  [N];

  for (genvar g = 0; g < N; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base[g] <= '0;
        cur[g]  <= '0;
      end else if (init && init_idx == IW'(g)) begin
        base[g] <= init_val;
        cur[g]  <= init_val;
      end else if (bump && bump_idx == IW'(g)) begin
        cur[g]  <= cur[g] + CW'(1);
      end
    end
  end

  assign cur_val = cur[bump_idx];
  assign rd_off  = base[rd_idx];
endmodule

// File: rtl/coo_nbr_store.sv
module coo_nbr_store #(
  parameter int DEPTH = 32,
  parameter int DW    = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[g] <= '0;
      else if (we && waddr == AW'(g))
        mem[g] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/coo_nbr_builder.sv
module coo_nbr_builder
  import coo_nbr_pkg::*;
#(
  parameter int MAX_NODES = 16,
  parameter int MAX_EDGES = 32,
  localparam int NW  = (MAX_NODES > 1) ? $clog2(MAX_NODES) : 1,
  localparam int NCW = $clog2(MAX_NODES + 1),
  localparam int ECW = $clog2(MAX_EDGES + 1),
  localparam int EIW = (MAX_EDGES > 1) ? $clog2(MAX_EDGES) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [NCW-1:0] num_nodes,
  input  logic [ECW-1:0] num_edges,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [NW-1:0]  in_src,
  input  logic [NW-1:0]  in_dst,
  output logic           busy,
  output logic           done,
  output logic           err,
  input  logic [NW-1:0]  rd_node,
  output logic [ECW-1:0] rd_indeg,
  output logic [ECW-1:0] rd_outdeg,
  output logic [ECW-1:0] rd_offset,
  input  logic [EIW-1:0] rd_slot,
  output logic [NW-1:0]  rd_nbr
);
  typedef struct packed {
    logic [NW-1:0] src;
    logic [NW-1:0] dst;
    logic          ok;
  } edge_t;

  phase_e         ph;
  logic [NCW-1:0] nn_q;
  logic [ECW-1:0] ne_q;
  logic [NCW-1:0] ni;
  logic [ECW-1:0] ei;
  logic [ECW-1:0] acc;
  edge_t          emem [MAX_EDGES];

  logic           take_hs, take_ok, clr_en, scan_en, place_en;
  logic [ECW-1:0] indeg_scan, unused_out_b, cur_val;
  edge_t          pe;

  assign in_ready = (ph == PH_TAKE);
  assign busy     = (ph != PH_IDLE);
  assign take_hs  = in_ready && in_valid;
  assign take_ok  = (NCW'(in_src) < nn_q) && (NCW'(in_dst) < nn_q);
  assign clr_en   = (ph == PH_CLEAR) && (ni != nn_q);
  assign scan_en  = (ph == PH_SCAN) && (ni != nn_q);
  assign pe       = emem[ei[EIW-1:0]];
  assign place_en = (ph == PH_PLACE) && (ei != ne_q) && pe.ok;

  coo_deg_table #(.N(MAX_NODES), .CW(ECW)) u_indeg (
    .clk, .rst_n,
    .clr(clr_en), .clr_idx(ni[NW-1:0]),
    .inc(take_hs && take_ok), .inc_idx(in_dst),
    .rd_a_idx(rd_node), .rd_a(rd_indeg),
    .rd_b_idx(ni[NW-1:0]), .rd_b(indeg_scan)
  );

  coo_deg_table #(.N(MAX_NODES), .CW(ECW)) u_outdeg (
    .clk, .rst_n,
    .clr(clr_en), .clr_idx(ni[NW-1:0]),
    .inc(take_hs && take_ok), .inc_idx(in_src),
    .rd_a_idx(rd_node), .rd_a(rd_outdeg),
    .rd_b_idx(ni[NW-1:0]), .rd_b(unused_out_b)
  );

  coo_block_cursor #(.N(MAX_NODES), .CW(ECW)) u_cursor (
    .clk, .rst_n,
    .init(scan_en), .init_idx(ni[NW-1:0]), .init_val(acc),
    .bump(place_en), .bump_idx(pe.dst), .cur_val(cur_val),
    .rd_idx(rd_node), .rd_off(rd_offset)
  );

  coo_nbr_store #(.DEPTH(MAX_EDGES), .DW(NW)) u_nbr (
    .clk, .rst_n,
    .we(place_en), .waddr(cur_val[EIW-1:0]), .wdata(pe.src),
    .raddr(rd_slot), .rdata(rd_nbr)
  );

  for (genvar g = 0; g < MAX_EDGES; g++) begin : g_emem
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        emem[g] <= '0;
      else if (take_hs && ei[EIW-1:0] == EIW'(g))
        emem[g] <= '{src: in_src, dst: in_dst, ok: take_ok};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= PH_IDLE;
      nn_q <= '0;
      ne_q <= '0;
      ni   <= '0;
      ei   <= '0;
      acc  <= '0;
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (ph)
        PH_IDLE: if (start) begin
          nn_q <= (num_nodes > NCW'(MAX_NODES)) ? NCW'(MAX_NODES) : num_nodes;
          ne_q <= (num_edges > ECW'(MAX_EDGES)) ? ECW'(MAX_EDGES) : num_edges;
          ni   <= '0;
          ei   <= '0;
          err  <= 1'b0;
          ph   <= PH_CLEAR;
        end
        PH_CLEAR: begin
          if (ni == nn_q) begin
            ni  <= '0;
            acc <= '0;
            ph  <= (ne_q == '0) ? PH_SCAN : PH_TAKE;
          end else begin
            ni <= ni + NCW'(1);
          end
        end
        PH_TAKE: if (in_valid) begin
          if (!take_ok) err <= 1'b1;
          if (ei == ne_q - ECW'(1)) begin
            ei <= '0;
            ph <= PH_SCAN;
          end else begin
            ei <= ei + ECW'(1);
          end
        end
        PH_SCAN: begin
          if (ni == nn_q) begin
            ei <= '0;
            ph <= PH_PLACE;
          end else begin
            acc <= acc + indeg_scan;
            ni  <= ni + NCW'(1);
          end
        end
        PH_PLACE: begin
          if (ei == ne_q) begin
            done <= 1'b1;
            ph   <= PH_IDLE;
          end else begin
            ei <= ei + ECW'(1);
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/coo_nbr_builder_chk.sv
module coo_nbr_builder_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic in_valid,
  input logic in_ready,
  input logic busy,
  input logic done,
  input logic err
);
  // R3
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !in_ready);

  // R2
  start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $fell(busy));

  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(err));

  // R7
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> !err);
endmodule

bind coo_nbr_builder coo_nbr_builder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
  .in_ready(in_ready), .busy(busy), .done(done), .err(err)
);

// File: tb/tb_coo_nbr_builder.sv
module tb_coo_nbr_builder;
  localparam int MAXN = 16;
  localparam int MAXE = 32;
  localparam int NW   = $clog2(MAXN);
  localparam int NCW  = $clog2(MAXN + 1);
  localparam int ECW  = $clog2(MAXE + 1);
  localparam int EIW  = $clog2(MAXE);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [NCW-1:0] num_nodes = '0;
  logic [ECW-1:0] num_edges = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [NW-1:0] in_src = '0, in_dst = '0;
  logic busy, done, err;
  logic [NW-1:0] rd_node = '0;
  logic [ECW-1:0] rd_indeg, rd_outdeg, rd_offset;
  logic [EIW-1:0] rd_slot = '0;
  logic [NW-1:0] rd_nbr;

  always #2 clk = ~clk;

  coo_nbr_builder #(.MAX_NODES(MAXN), .MAX_EDGES(MAXE)) dut (
    .clk, .rst_n, .start, .num_nodes, .num_edges,
    .in_valid, .in_ready, .in_src, .in_dst,
    .busy, .done, .err,
    .rd_node, .rd_indeg, .rd_outdeg, .rd_offset,
    .rd_slot, .rd_nbr
  );

  typedef struct {
    int kind;
    int idx;
    int val;
  } exp_t;

  exp_t sb_q[$];
  int checks = 0;
  int errors = 0;
  int graphs_seen = 0;
  int e_src [MAXE];
  int e_dst [MAXE];

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Monitor: drains the scoreboard after each done pulse
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        check("R8", "busy low with done", int'(busy), 0);
        while (sb_q.size() > 0) begin
          exp_t it;
          it = sb_q.pop_front();
          case (it.kind)
            0: begin rd_node = NW'(it.idx); #1; check("R4", $sformatf("indeg[%0d]", it.idx), int'(rd_indeg), it.val); end
            1: begin rd_node = NW'(it.idx); #1; check("R4", $sformatf("outdeg[%0d]", it.idx), int'(rd_outdeg), it.val); end
            2: begin rd_node = NW'(it.idx); #1; check("R5", $sformatf("offset[%0d]", it.idx), int'(rd_offset), it.val); end
            3: begin rd_slot = EIW'(it.idx); #1; check("R6", $sformatf("nbr[%0d]", it.idx), int'(rd_nbr), it.val); end
            default: check("R7", "err flag", int'(err), it.val);
          endcase
        end
        graphs_seen++;
      end
    end
  end

  // Driver: computes expected tables, pushes them, then runs the graph
  task automatic run_graph(input int nn, input int ne, input int gap_mod, input bit poke_start);
    int indeg [MAXN];
    int outdeg [MAXN];
    int off [MAXN];
    int cur [MAXN];
    int nbr [MAXE];
    int bad = 0;
    int total = 0;
    int target;
    exp_t it;
    for (int i = 0; i < MAXN; i++) begin indeg[i] = 0; outdeg[i] = 0; end
    for (int k = 0; k < ne; k++) begin
      if (e_src[k] < nn && e_dst[k] < nn) begin
        indeg[e_dst[k]]++;
        outdeg[e_src[k]]++;
      end else bad = 1;
    end
    for (int i = 0; i < nn; i++) begin
      off[i] = total; cur[i] = total; total += indeg[i];
    end
    for (int k = 0; k < ne; k++) begin
      if (e_src[k] < nn && e_dst[k] < nn) begin
        nbr[cur[e_dst[k]]] = e_src[k];
        cur[e_dst[k]]++;
      end
    end
    for (int i = 0; i < nn; i++) begin
      it = '{0, i, indeg[i]};  sb_q.push_back(it);
      it = '{1, i, outdeg[i]}; sb_q.push_back(it);
      it = '{2, i, off[i]};    sb_q.push_back(it);
    end
    for (int s = 0; s < total; s++) begin
      it = '{3, s, nbr[s]}; sb_q.push_back(it);
    end
    it = '{4, 0, bad}; sb_q.push_back(it);
    target = graphs_seen + 1;

    @(negedge clk);
    num_nodes = NCW'(nn);
    num_edges = ECW'(ne);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2", "busy after start", int'(busy), 1);
    for (int k = 0; k < ne; k++) begin
      if (gap_mod > 0 && (k % gap_mod) == 1) begin
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
      end
      in_valid = 1'b1;
      in_src = NW'(e_src[k]);
      in_dst = NW'(e_dst[k]);
      while (!in_ready) @(negedge clk);
      if (poke_start && k == 2) begin
        // R2: start while busy, with different counts, must be ignored
        start = 1'b1;
        num_nodes = NCW'(1);
        num_edges = ECW'(1);
      end
      @(negedge clk);
      start = 1'b0;
    end
    in_valid = 1'b0;
    @(negedge clk);
    check("R3", "ready low after intake", int'(in_ready), 0);
    while (graphs_seen < target) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "busy", int'(busy), 0);
    check("R1", "done", int'(done), 0);
    check("R1", "err", int'(err), 0);
    check("R1", "in_ready", int'(in_ready), 0);
    rd_node = 3; rd_slot = 7; #1;
    check("R1", "indeg", int'(rd_indeg), 0);
    check("R1", "offset", int'(rd_offset), 0);
    check("R1", "nbr", int'(rd_nbr), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R3", "ready low while idle", int'(in_ready), 0);

    // Graph A: mixed edges, repeated destinations, no stalls (R4 R5 R6)
    e_src[0]=0; e_dst[0]=1;  e_src[1]=2; e_dst[1]=1;
    e_src[2]=3; e_dst[2]=0;  e_src[3]=1; e_dst[3]=4;
    e_src[4]=4; e_dst[4]=1;  e_src[5]=0; e_dst[5]=3;
    e_src[6]=2; e_dst[6]=0;  e_src[7]=3; e_dst[7]=3;
    run_graph(5, 8, 0, 1'b0);

    // Graph B: stalls, out-of-range edges, start poked while busy (R2 R3 R7)
    e_src[0]=1; e_dst[0]=2;  e_src[1]=7; e_dst[1]=2;
    e_src[2]=5; e_dst[2]=0;  e_src[3]=2; e_dst[3]=5;
    e_src[4]=0; e_dst[4]=9;  e_src[5]=3; e_dst[5]=2;
    e_src[6]=4; e_dst[6]=4;
    run_graph(6, 7, 3, 1'b1);

    // Graph C: no edges after a dense graph, err cleared (R9 R7)
    run_graph(4, 0, 0, 1'b0);

    // Graph D: full size graph (R4 R5 R6)
    for (int k = 0; k < MAXE; k++) begin
      e_src[k] = (k * 7 + 3) % MAXN;
      e_dst[k] = (k * 5 + 1) % MAXN;
    end
    run_graph(MAXN, MAXE, 5, 1'b0);

    report();
  end
endmodule